// File: doc/BRIEF.md
# Page-Directory DMA Address Translator

This block sits between a PCI-side DMA master and system memory. It turns an I/O virtual address into a system physical page address. Pages are 4 KB, and translation goes through a single-level page directory held in memory. A request is first compared against a programmable window, made of a base register with an enable bit and a mask register. An address that falls outside the window, or any address while the window is disabled, passes straight through with read/write permission.

An address inside the window starts a fetch of one 64-bit directory entry, indexed by the page number. The entry either supplies the physical page or, when its top bit is clear, produces a fault with no permission. The block handles one request at a time and holds the requester off while the entry fetch is outstanding.

The configuration space holds five 64-bit registers: window base, window mask, purge command, translation config and directory base. Each of them answers at two offsets.

Top module: `iova_pagedir_xlate`

## Requirements
- R1: After reset, all five configuration registers read 0, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: Full 64-bit configuration registers sit at byte offsets 0x300 (window base), 0x308 (window mask), 0x310 (purge command), 0x318 (translation config) and 0x320 (directory base). Offsets 0x2300 to 0x2320 reach the same storage. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R3: When window base bit 0 is 0, a request bypasses translation. The response carries `rsp_page` equal to the request with its low 12 bits cleared, with `rsp_rw`=1 and `rsp_fault`=0. No memory read is issued, and `rsp_valid` is high in the cycle after acceptance.
- R4: When base bit 0 is 1 but ((iova with low 12 bits cleared) & mask) differs from (base with bit 0 cleared), the request bypasses exactly as in R3.
- R5: On a window hit, exactly one memory read is issued, in the cycle after acceptance, at the address directory_base + (iova >> 12) * 8.
- R6: If the returned entry has bit 63 = 0, the response has `rsp_fault`=1, `rsp_rw`=0 and `rsp_page`=0.
- R7: If the returned entry has bit 63 = 1, `rsp_page` is the entry with bit 63 and bits 11:0 cleared, with `rsp_rw`=1 and `rsp_fault`=0.
- R8: `mem_rd_valid` is a single-cycle pulse. Read data is taken only in the cycles after that pulse. A translated response is high in the cycle after read data is taken, and `rsp_valid` lasts one cycle.
- R9: Only one request is in flight. `req_ready` is 0 from the cycle after acceptance through the response cycle and returns to 1 in the following cycle. A request held during that time is accepted only afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 16 | Configuration write byte offset |
| cfg_wr_data | input | 64 | Configuration write data |
| cfg_rd_addr | input | 16 | Configuration read byte offset |
| cfg_rd_data | output | 64 | Configuration read data (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_iova | input | 64 | I/O virtual address |
| mem_rd_valid | output | 1 | Directory entry read request |
| mem_rd_addr | output | 64 | Byte address of the directory entry |
| mem_rd_data_valid | input | 1 | Directory entry data present |
| mem_rd_data | input | 64 | Directory entry, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_iova | output | 64 | Request address with the low 12 bits cleared |
| rsp_page | output | 64 | Resulting physical page address |
| rsp_rw | output | 1 | Read/write permission granted |
| rsp_fault | output | 1 | Translation fault, no permission |

## Verification
The assertions assume that memory returns entry data only after the read pulse. They also assume that `mem_rd_data_valid` stays low whenever no read is outstanding, and that the requester waits for `req_ready`. The bench memory model raises data strictly after the pulse, with zero to several idle cycles of delay. It issues a new request only while the block is idle, except in one directed case where a request is held on purpose during a fetch. Random windows, masks, directory bases and entries are chosen so that hits, misses, disabled windows and invalid entries all occur. The expected results come from bench functions that apply the window and entry rules.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;

  localparam int unsigned CFG_NREG    = 5;
  localparam int unsigned CFG_BASE    = 0;
  localparam int unsigned CFG_MASK    = 1;
  localparam int unsigned CFG_PURGE   = 2;
  localparam int unsigned CFG_TLBCFG  = 3;
  localparam int unsigned CFG_DIRBASE = 4;
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import xlate_pkg::*;
#(
  parameter int unsigned        ADDR_W  = 64,
  parameter int unsigned        CFG_AW  = 16,
  parameter logic [CFG_AW-1:0]  PRI_OFS = 16'h0300,
  parameter logic [CFG_AW-1:0]  ALT_OFS = 16'h2300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [CFG_AW-1:0] rd_addr,
  output logic [ADDR_W-1:0] rd_data,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic [ADDR_W-1:0] dirbase_o
);
  localparam int unsigned NREG = CFG_NREG;

  logic [ADDR_W-1:0] regs_q [NREG];
  logic [ADDR_W-1:0] regs_d [NREG];
  logic [NREG-1:0]   wsel;
  logic [NREG-1:0]   rsel;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [CFG_AW-1:0] OFS_P = PRI_OFS + CFG_AW'(i * 8);
    localparam logic [CFG_AW-1:0] OFS_A = ALT_OFS + CFG_AW'(i * 8);

    assign wsel[i] = (wr_addr == OFS_P) || (wr_addr == OFS_A);
    assign rsel[i] = (rd_addr == OFS_P) || (rd_addr == OFS_A);

    always_comb begin
      regs_d[i] = regs_q[i];
      if (wr_en && wsel[i]) regs_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rsel[i]) rd_data = rd_data | regs_q[i];
    end
  end

  assign base_o    = regs_q[CFG_BASE];
  assign mask_o    = regs_q[CFG_MASK];
  assign dirbase_o = regs_q[CFG_DIRBASE];

  // R2: without a write strobe the window and directory settings hold
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_o) && $stable(mask_o) && $stable(dirbase_o)));

  // R2: two offsets never decode to more than one register
  a_r2_unique_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
endmodule

// File: rtl/xlate_window.sv
module xlate_window #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] page_i,
  output logic              hit_o
);
  logic              range_en;
  logic [ADDR_W-1:0] match_val;

  assign range_en  = base_i[0];
  assign match_val = {base_i[ADDR_W-1:1], 1'b0};
  assign hit_o     = range_en && ((page_i & mask_i) == match_val);
endmodule

// File: rtl/xlate_entry_dec.sv
module xlate_entry_dec #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] entry_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] page_o
);
  localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TOP_BIT  = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] KEEP     = ~(OFS_MASK | TOP_BIT);

  assign valid_o = |(entry_i & TOP_BIT);
  assign page_o  = entry_i & KEEP;
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic              win_hit,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_data_valid,
  input  logic              ent_valid,
  input  logic [ADDR_W-1:0] ent_page,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_iova,
  output logic [ADDR_W-1:0] rsp_page,
  output logic              rsp_rw,
  output logic              rsp_fault
);
  xl_state_e         state_q, state_d;
  logic [ADDR_W-1:0] iova_q, iova_d;
  logic [ADDR_W-1:0] fetch_q, fetch_d;
  logic [ADDR_W-1:0] page_q, page_d;
  logic              rw_q, rw_d;
  logic              fault_q, fault_d;
  logic              acc_en;
  logic              data_en;

  assign acc_en  = (state_q == ST_IDLE) && req_valid;
  assign data_en = (state_q == ST_WAIT) && mem_rd_data_valid;

  always_comb begin
    state_d = state_q;
    iova_d  = iova_q;
    fetch_d = fetch_q;
    page_d  = page_q;
    rw_d    = rw_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_en) begin
          iova_d = page_addr;
          if (win_hit) begin
            fetch_d = fetch_addr;
            state_d = ST_FETCH;
          end else begin
            page_d  = page_addr;
            rw_d    = 1'b1;
            fault_d = 1'b0;
            state_d = ST_RESP;
          end
        end
      end
      ST_FETCH: state_d = ST_WAIT;
      ST_WAIT: begin
        if (data_en) begin
          page_d  = ent_valid ? ent_page : '0;
          rw_d    = ent_valid;
          fault_d = !ent_valid;
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iova_q  <= '0;
      fetch_q <= '0;
      page_q  <= '0;
      rw_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_en) begin
        iova_q  <= iova_d;
        fetch_q <= fetch_d;
      end
      if (acc_en || data_en) begin
        page_q  <= page_d;
        rw_q    <= rw_d;
        fault_q <= fault_d;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_FETCH);
  assign mem_rd_addr  = fetch_q;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_iova     = iova_q;
  assign rsp_page     = page_q;
  assign rsp_rw       = rw_q;
  assign rsp_fault    = fault_q;

  // R3 R4: a request outside the window responds in the next cycle
  a_r3_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !win_hit) |=> (rsp_valid && !mem_rd_valid));

  // R5: a window hit issues the entry read in the next cycle
  a_r5_fetch_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit) |=> (mem_rd_valid && !rsp_valid));

  // R8: the read request is a single pulse
  a_r8_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  // R8: the response follows the cycle in which data is taken and lasts one cycle
  a_r8_data_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rd_data_valid) |=> rsp_valid);
  a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R9: nothing is accepted while a response is presented
  a_r9_no_ready_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R6: a fault never carries permission
  a_r6_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != rsp_rw));
endmodule

// File: rtl/iova_pagedir_xlate.sv
module iova_pagedir_xlate #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned CFG_AW      = 16,
  parameter int unsigned PAGE_SHIFT  = 12,
  parameter int unsigned ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic [CFG_AW-1:0] cfg_rd_addr,
  output logic [ADDR_W-1:0] cfg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_iova,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_data_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_iova,
  output logic [ADDR_W-1:0] rsp_page,
  output logic              rsp_rw,
  output logic              rsp_fault
);
  localparam int unsigned       ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_KEEP   = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

  logic [ADDR_W-1:0] base_w, mask_w, dirbase_w;
  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] dir_index;
  logic [ADDR_W-1:0] fetch_addr;
  logic              win_hit;
  logic              ent_valid;
  logic [ADDR_W-1:0] ent_page;

  assign page_addr  = req_iova & PAGE_KEEP;
  assign dir_index  = req_iova >> PAGE_SHIFT;
  assign fetch_addr = dirbase_w + (dir_index << ENTRY_SHIFT);

  xlate_cfg_regs #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_addr   (cfg_wr_addr),
    .wr_data   (cfg_wr_data),
    .rd_addr   (cfg_rd_addr),
    .rd_data   (cfg_rd_data),
    .base_o    (base_w),
    .mask_o    (mask_w),
    .dirbase_o (dirbase_w)
  );

  xlate_window #(.ADDR_W(ADDR_W)) u_win (
    .base_i (base_w),
    .mask_i (mask_w),
    .page_i (page_addr),
    .hit_o  (win_hit)
  );

  xlate_entry_dec #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
    .entry_i (mem_rd_data),
    .valid_o (ent_valid),
    .page_o  (ent_page)
  );

  xlate_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .page_addr         (page_addr),
    .win_hit           (win_hit),
    .fetch_addr        (fetch_addr),
    .mem_rd_valid      (mem_rd_valid),
    .mem_rd_addr       (mem_rd_addr),
    .mem_rd_data_valid (mem_rd_data_valid),
    .ent_valid         (ent_valid),
    .ent_page          (ent_page),
    .rsp_valid         (rsp_valid),
    .rsp_iova          (rsp_iova),
    .rsp_page          (rsp_page),
    .rsp_rw            (rsp_rw),
    .rsp_fault         (rsp_fault)
  );

  // R7: a granted translated page is always page aligned
  a_r7_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_page & ~PAGE_KEEP) == '0));
endmodule

// File: tb/tb_iova_pagedir_xlate.sv
module tb_iova_pagedir_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_addr;
  logic [63:0] cfg_wr_data;
  logic [15:0] cfg_rd_addr;
  logic [63:0] cfg_rd_data;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_iova;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [63:0] mem_rd_data;
  logic        rsp_valid;
  logic [63:0] rsp_iova;
  logic [63:0] rsp_page;
  logic        rsp_rw;
  logic        rsp_fault;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iova_pagedir_xlate dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pg(input logic [63:0] a);
    return a & ~64'hfff;
  endfunction

  function automatic bit exp_hit(input logic [63:0] b, input logic [63:0] m, input logic [63:0] a);
    return b[0] && ((pg(a) & m) == (b & ~64'h1));
  endfunction

  function automatic logic [63:0] exp_fetch(input logic [63:0] d, input logic [63:0] a);
    return d + ((a >> 12) << 3);
  endfunction

  function automatic logic [63:0] exp_page(input logic [63:0] e);
    return e[63] ? (e & 64'h7fff_ffff_ffff_f000) : 64'h0;
  endfunction

  task automatic cfg_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_chk(input string tag, input logic [15:0] a, input logic [63:0] e);
    cfg_rd_addr = a;
    #1;
    chk(tag, cfg_rd_data, e);
  endtask

  // runs one request; b, m, d are the programmed window base, mask, directory base
  task automatic run_req(input logic [63:0] a, input logic [63:0] ent, input int dly,
                         input logic [63:0] b, input logic [63:0] m, input logic [63:0] d);
    bit hit;
    hit = exp_hit(b, m, a);
    @(negedge clk);
    req_valid = 1'b1; req_iova = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) begin
      chk("R3/R4 bypass rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R3/R4 bypass page", rsp_page, pg(a));
      chk("R3/R4 bypass rw", 64'(rsp_rw), 64'd1);
      chk("R3/R4 bypass fault", 64'(rsp_fault), 64'd0);
      chk("R3/R4 no memory read", 64'(mem_rd_valid), 64'd0);
    end else begin
      chk("R5 read issued", 64'(mem_rd_valid), 64'd1);
      chk("R5 read address", mem_rd_addr, exp_fetch(d, a));
      chk("R9 held off", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk("R8 read pulse single", 64'(mem_rd_valid), 64'd0);
      for (int k = 0; k < dly; k++) begin
        chk("R8 no early response", 64'(rsp_valid), 64'd0);
        @(negedge clk);
      end
      mem_rd_data_valid = 1'b1; mem_rd_data = ent;
      @(negedge clk);
      mem_rd_data_valid = 1'b0; mem_rd_data = 64'h0;
      chk("R8 translated rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R7/R6 page", rsp_page, exp_page(ent));
      chk("R7/R6 rw", 64'(rsp_rw), 64'(ent[63]));
      chk("R6 fault", 64'(rsp_fault), 64'(!ent[63]));
      chk("R9 no ready in response", 64'(req_ready), 64'd0);
    end
    chk("R3 rsp_iova", rsp_iova, pg(a));
    @(negedge clk);
    chk("R8 response one cycle", 64'(rsp_valid), 64'd0);
    chk("R9 ready again", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] b, m, d, a, e;
    void'($urandom(32'd7351));
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0; cfg_rd_addr = '0;
    req_valid = 1'b0; req_iova = '0; mem_rd_data_valid = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    for (int i = 0; i < 5; i++) begin
      cfg_chk("R1 cfg zero", 16'h0300 + 16'(i * 8), 64'h0);
      cfg_chk("R1 cfg alias zero", 16'h2300 + 16'(i * 8), 64'h0);
    end

    // R2: storage, aliases, unmapped offsets
    cfg_wr(16'h0310, 64'hdead_beef_0000_1111);
    cfg_wr(16'h2318, 64'h0123_4567_89ab_cdef);
    cfg_chk("R2 purge via alias", 16'h2310, 64'hdead_beef_0000_1111);
    cfg_chk("R2 tlbcfg via primary", 16'h0318, 64'h0123_4567_89ab_cdef);
    cfg_wr(16'h0328, 64'hffff_ffff_ffff_ffff);
    cfg_wr(16'h0304, 64'hffff_ffff_ffff_ffff);
    cfg_chk("R2 unmapped read zero", 16'h0328, 64'h0);
    cfg_chk("R2 unmapped write ignored base", 16'h0300, 64'h0);
    cfg_chk("R2 unmapped write ignored mask", 16'h0308, 64'h0);
    cfg_chk("R2 unmapped write ignored dirbase", 16'h0320, 64'h0);

    // R3: disabled window, address above 4 GB passes unchanged
    run_req(64'h0000_0012_3456_7abc, 64'h0, 0, 64'h0, 64'h0, 64'h0);

    // R4 / R5 / R7: mask 0 with enable makes every address hit
    cfg_wr(16'h2300, 64'h1);
    cfg_wr(16'h0320, 64'h0000_0000_8000_0000);
    run_req(64'h0000_0000_0004_5fff, 64'h8000_00ab_cdef_1fff, 2,
            64'h1, 64'h0, 64'h0000_0000_8000_0000);
    // R6: invalid entry faults
    run_req(64'h0000_0000_0000_0123, 64'h7fff_ffff_ffff_ffff, 0,
            64'h1, 64'h0, 64'h0000_0000_8000_0000);

    // R9: a request held during a fetch is taken only after the response
    @(negedge clk);
    req_valid = 1'b1; req_iova = 64'h0000_0000_0001_0000;
    @(negedge clk);
    req_iova = 64'h0000_0000_0009_9000;
    chk("R9 fetch started", 64'(mem_rd_valid), 64'd1);
    chk("R9 held off during fetch", 64'(req_ready), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 held off during wait", 64'(req_ready), 64'd0);
    mem_rd_data_valid = 1'b1; mem_rd_data = 64'h8000_0000_0777_7000;
    @(negedge clk);
    mem_rd_data_valid = 1'b0;
    chk("R9 first response page", rsp_page, 64'h0000_0000_0777_7000);
    chk("R9 first response iova", rsp_iova, 64'h0000_0000_0001_0000);
    @(negedge clk);
    chk("R9 ready after response", 64'(req_ready), 64'd1);
    cfg_wr_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second request fetched", 64'(mem_rd_valid), 64'd1);
    chk("R9 second fetch address", mem_rd_addr, exp_fetch(64'h8000_0000, 64'h0000_0000_0009_9000));
    @(negedge clk);
    mem_rd_data_valid = 1'b1; mem_rd_data = 64'h0;
    @(negedge clk);
    mem_rd_data_valid = 1'b0;
    chk("R9 second response fault", 64'(rsp_fault), 64'd1);
    @(negedge clk);

    // random windows, masks, directory bases and entries
    for (int it = 0; it < 80; it++) begin
      int mode;
      mode = int'($urandom % 4);
      case ($urandom % 3)
        0: m = 64'hffff_ffff_ff00_0000;
        1: m = 64'hffff_ffff_f000_0000;
        default: m = 64'h0000_00ff_fff0_0000;
      endcase
      b = ({$urandom, $urandom} & m) | 64'(mode != 0);
      d = {$urandom, $urandom} & 64'h0000_00ff_ffff_f000;
      a = (b & ~64'h1 & m) | ({$urandom, $urandom} & ~m);
      if (mode == 1) a = a ^ (m & (~m + 64'h1));
      e = {$urandom, $urandom};
      e[63] = (mode != 3);
      cfg_wr((it % 2) ? 16'h2300 : 16'h0300, b);
      cfg_wr((it % 3) ? 16'h0308 : 16'h2308, m);
      cfg_wr(16'h0320, d);
      run_req(a, e, int'($urandom % 4), b, m, d);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule